// File: doc/BRIEF.md
# Non-Overlapping Converter Switch Driver

This block turns a phase clock into the two gate levels of an inductive converter's power stage: a high-side PMOS (on when its gate is low) and a low-side NMOS (on when its gate is high). Two harvesting paths share the stage. The thermal path always runs as a boost converter. The vibration path runs as a boost or a buck converter, chosen by a select input. Each path has its own zero-current flag, which marks the moment the inductor current has fallen back to zero.

While the phase clock is high, the charge switch conducts. That is the low-side switch in boost and the high-side switch in buck. After the phase clock falls, the other switch (the release switch) conducts until the active path's zero-current flag rises or the next phase begins. Both switches then stay off. Every turn-on of either switch comes after a dead gap of `DEAD_GAP` system-clock cycles with both switches off.

The source and mode are captured only while the stage is idle, so a role swap can never happen while current flows. Dropping the enable turns both switches off in the same cycle.

The controller has five states:
- `ST_IDLE`: both switches off.
- `ST_GAP_CHG`: dead gap before the charge switch turns on.
- `ST_CHARGE`: the charge switch is on.
- `ST_GAP_REL`: dead gap before the release switch turns on.
- `ST_RELEASE`: the release switch is on.

The transitions are:
- Phase high in idle starts the charge gap.
- The charge gap ends in charge, or returns to idle if the phase falls first.
- Phase low in charge starts the release gap.
- The release gap ends in release. It goes to idle on a zero-current event, or back to the charge gap on a new phase.
- Release ends in idle on a zero-current event, or in the charge gap on a new phase.
- Enable low sends any state to idle.

Top module: `nsd_switch_driver`

## Requirements
- R1: While `rst_n` is low, and after reset, both switches are off (`hs_gate_n` = 1, `ls_gate` = 0).
- R2: In no cycle are both switches on, meaning `hs_gate_n` = 0 and `ls_gate` = 1 together.
- R3: In boost mode, the charge switch is the low-side switch. The thermal path (`src_sel` = 0) is always boost, and the vibration path (`src_sel` = 1) is boost when `buck_sel` = 0. While the phase is high after the dead gap, `ls_gate` = 1 and `hs_gate_n` = 1.
- R4: In boost mode, after the phase falls and the dead gap passes, the high-side switch conducts (`hs_gate_n` = 0, `ls_gate` = 0).
- R5: In buck mode (`src_sel` = 1, `buck_sel` = 1), the high-side switch conducts while the phase is high. The low-side switch conducts during freewheeling after the phase falls.
- R6: A zero-current event ends the release interval, and both switches are off from the next cycle. The event is the flag of the captured source (`zc_thermal` for source 0, `zc_vib` for source 1) seen during the release state or the release gap. The flag of the other source is ignored, and so is a zero-current flag seen while charging.
- R7: Any switch turn-on is preceded by at least `DEAD_GAP` consecutive cycles with both switches off. Each gap state lasts exactly `DEAD_GAP` cycles.
- R8: When `enable` is low, both switches are off within the same cycle and the controller returns to idle. Once `enable` comes back, a new charge begins only after a full dead gap.
- R9: `src_sel` and `buck_sel` are captured only in the idle state. Changes outside idle have no effect until the next idle. `buck_sel` has no effect on the thermal path.
- R10: A phase rise during release, with no zero-current event, turns the release switch off. The charge switch then turns on after a dead gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run permission; low forces both switches off |
| phase | input | 1 | Phase clock of the selected source; high = charge interval |
| src_sel | input | 1 | 0 = thermal path, 1 = vibration path |
| buck_sel | input | 1 | Vibration path only: 1 = buck, 0 = boost |
| zc_thermal | input | 1 | Zero-current flag of the thermal path |
| zc_vib | input | 1 | Zero-current flag of the vibration path |
| hs_gate_n | output | 1 | High-side PMOS gate level; 0 = switch on |
| ls_gate | output | 1 | Low-side NMOS gate level; 1 = switch on |

## Verification
The bench builds the block with `DEAD_GAP` = 3 rather than the default of 2. With that value, an off-by-one in the gap counter or in the gap-state exits changes the cycle in which each switch turns on, and the bench samples exactly that cycle. A gap of three cycles also leaves room inside the release gap to inject a zero-current event or a new phase before the gap ends. That reaches the early exits from `ST_GAP_REL` and the restart of the counter when one gap state follows another.

// File: rtl/nsd_pkg.sv
package nsd_pkg;

    // Controller states of the switch driver.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_GAP_CHG = 3'd1,
        ST_CHARGE  = 3'd2,
        ST_GAP_REL = 3'd3,
        ST_RELEASE = 3'd4
    } nsd_state_e;

    // Captured role of the power stage for one conversion cycle.
    typedef struct packed {
        logic vib;   // 1 = vibration path, 0 = thermal path
        logic buck;  // 1 = buck operation (vibration path only)
    } nsd_role_t;

endpackage

// File: rtl/nsd_gap_timer.sv
module nsd_gap_timer #(
    parameter int DEAD_GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic done
);
    localparam int GAP_EFF = (DEAD_GAP < 1) ? 1 : DEAD_GAP;
    localparam int CW      = $clog2(GAP_EFF + 1);
    localparam logic [CW-1:0] CMAX = CW'(GAP_EFF - 1);

    logic [CW-1:0] cnt_q;

    // Counts cycles spent in the current state; saturates at the gap end.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (cnt_q != CMAX) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    always_comb begin
        done = (cnt_q == CMAX);
    end

endmodule

// File: rtl/nsd_role_latch.sv
module nsd_role_latch
    import nsd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  logic      src_sel,
    input  logic      buck_sel,
    input  logic      zc_thermal,
    input  logic      zc_vib,
    output nsd_role_t role_q,
    output logic      zc_active
);
    nsd_role_t role_d;

    // Thermal path is boost-only: buck select is masked for it.
    always_comb begin
        role_d.vib  = src_sel;
        role_d.buck = src_sel & buck_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            role_q <= '0;
        end else if (load) begin
            role_q <= role_d;
        end
    end

    // Zero-current flag of the captured source only.
    always_comb begin
        zc_active = role_q.vib ? zc_vib : zc_thermal;
    end

endmodule

// File: rtl/nsd_fsm.sv
module nsd_fsm
    import nsd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       phase,
    input  logic       zc,
    input  logic       gap_done,
    output nsd_state_e state_q,
    output logic       gap_clear,
    output logic       role_load,
    output logic       chg_on,
    output logic       rel_on
);
    nsd_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (phase) state_d = ST_GAP_CHG;
                end
                ST_GAP_CHG: begin
                    if (!phase)        state_d = ST_IDLE;
                    else if (gap_done) state_d = ST_CHARGE;
                end
                ST_CHARGE: begin
                    if (!phase) state_d = ST_GAP_REL;
                end
                ST_GAP_REL: begin
                    if (phase)         state_d = ST_GAP_CHG;
                    else if (zc)       state_d = ST_IDLE;
                    else if (gap_done) state_d = ST_RELEASE;
                end
                ST_RELEASE: begin
                    if (phase)   state_d = ST_GAP_CHG;
                    else if (zc) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Output decode.
    always_comb begin
        chg_on    = (state_q == ST_CHARGE);
        rel_on    = (state_q == ST_RELEASE);
        role_load = (state_q == ST_IDLE);
        gap_clear = (state_d != state_q);
    end

    // R6: zero-current during release ends conduction.
    p_zc_ends_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_RELEASE && !phase && zc) |=> (state_q == ST_IDLE));

    // R7: the charge state is only entered through its gap state.
    p_charge_after_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHARGE && $past(state_q) != ST_CHARGE) |-> ($past(state_q) == ST_GAP_CHG));

    // R4: the release state is only entered through its gap state.
    p_release_after_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASE && $past(state_q) != ST_RELEASE) |-> ($past(state_q) == ST_GAP_REL));

    // R8: disable returns the controller to idle.
    p_disable_idles_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_q == ST_IDLE));

    // R10: a new phase during release restarts through the charge gap.
    p_phase_preempts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_RELEASE && phase) |=> (state_q == ST_GAP_CHG));

endmodule

// File: rtl/nsd_switch_driver.sv
module nsd_switch_driver
    import nsd_pkg::*;
#(
    parameter int DEAD_GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic phase,
    input  logic src_sel,
    input  logic buck_sel,
    input  logic zc_thermal,
    input  logic zc_vib,
    output logic hs_gate_n,
    output logic ls_gate
);
    localparam int GAP_EFF = (DEAD_GAP < 1) ? 1 : DEAD_GAP;
    localparam int OW      = $clog2(GAP_EFF + 1);

    nsd_state_e state_q;
    nsd_role_t  role_q;
    logic       zc_active;
    logic       gap_done;
    logic       gap_clear;
    logic       role_load;
    logic       chg_on;
    logic       rel_on;
    logic       hs_on;
    logic       ls_on;

    nsd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .phase     (phase),
        .zc        (zc_active),
        .gap_done  (gap_done),
        .state_q   (state_q),
        .gap_clear (gap_clear),
        .role_load (role_load),
        .chg_on    (chg_on),
        .rel_on    (rel_on)
    );

    nsd_gap_timer #(
        .DEAD_GAP (GAP_EFF)
    ) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (gap_clear),
        .done  (gap_done)
    );

    nsd_role_latch u_role (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (role_load),
        .src_sel    (src_sel),
        .buck_sel   (buck_sel),
        .zc_thermal (zc_thermal),
        .zc_vib     (zc_vib),
        .role_q     (role_q),
        .zc_active  (zc_active)
    );

    // Map charge/release roles onto physical switches; enable gates directly.
    always_comb begin
        hs_on     = enable & (role_q.buck ? chg_on : rel_on);
        ls_on     = enable & (role_q.buck ? rel_on : chg_on);
        hs_gate_n = ~hs_on;
        ls_gate   = ls_on;
    end

    // Assertion support: consecutive cycles with both gates off.
    logic [OW-1:0] off_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_run_q <= '0;
        end else if (hs_gate_n && !ls_gate) begin
            if (off_run_q != OW'(GAP_EFF)) off_run_q <= off_run_q + OW'(1);
        end else begin
            off_run_q <= '0;
        end
    end

    // R2: the two switches never conduct together.
    p_never_both_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!hs_gate_n && ls_gate));

    // R7: each turn-on follows a full dead gap at the pins.
    p_gap_before_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((!hs_gate_n && $past(hs_gate_n)) || (ls_gate && !$past(ls_gate)))
            |-> (off_run_q >= OW'(GAP_EFF)));

    // R9: captured role is held outside idle.
    p_role_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(role_q));

endmodule

// File: tb/nsd_switch_driver_tb.sv
module nsd_switch_driver_tb;

    localparam int GAP  = 3;
    localparam int NVEC = 48;

    logic clk = 1'b0;
    logic rst_n;
    logic enable, phase, src_sel, buck_sel, zc_thermal, zc_vib;
    logic hs_gate_n, ls_gate;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    nsd_switch_driver #(.DEAD_GAP(GAP)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .phase      (phase),
        .src_sel    (src_sel),
        .buck_sel   (buck_sel),
        .zc_thermal (zc_thermal),
        .zc_vib     (zc_vib),
        .hs_gate_n  (hs_gate_n),
        .ls_gate    (ls_gate)
    );

    // Vector: {req[3:0], en, ph, src, buck, zt, zv, exp_hs_n, exp_ls}
    localparam logic [11:0] VEC [NVEC] = '{
        {4'd7,  8'b1100_0010}, // 0  R7 charge gap, thermal boost
        {4'd7,  8'b1100_0010}, // 1
        {4'd7,  8'b1100_0010}, // 2
        {4'd3,  8'b1100_0011}, // 3  R3 low-side charges
        {4'd3,  8'b1100_0011}, // 4
        {4'd7,  8'b1000_0010}, // 5  R7 release gap
        {4'd7,  8'b1000_0010}, // 6
        {4'd7,  8'b1000_0010}, // 7
        {4'd4,  8'b1000_0000}, // 8  R4 high-side releases
        {4'd6,  8'b1000_0100}, // 9  R6 other source flag ignored
        {4'd6,  8'b1000_1010}, // 10 R6 own flag ends release
        {4'd6,  8'b1000_0010}, // 11
        {4'd7,  8'b1111_0010}, // 12 vibration buck captured
        {4'd7,  8'b1111_0010}, // 13
        {4'd7,  8'b1111_0010}, // 14
        {4'd5,  8'b1111_0000}, // 15 R5 high-side charges
        {4'd9,  8'b1100_0000}, // 16 R9 select change ignored
        {4'd7,  8'b1000_0010}, // 17
        {4'd7,  8'b1000_0010}, // 18
        {4'd7,  8'b1000_0010}, // 19
        {4'd5,  8'b1000_0011}, // 20 R5 low-side freewheels
        {4'd9,  8'b1000_1011}, // 21 R9 thermal flag ignored, vib captured
        {4'd6,  8'b1000_0110}, // 22 R6 vib flag ends release
        {4'd7,  8'b1101_0010}, // 23 thermal with buck select set
        {4'd7,  8'b1101_0010}, // 24
        {4'd7,  8'b1101_0010}, // 25
        {4'd9,  8'b1101_0011}, // 26 R9 thermal still boost
        {4'd7,  8'b1001_0010}, // 27
        {4'd7,  8'b1001_0010}, // 28
        {4'd7,  8'b1001_0010}, // 29
        {4'd4,  8'b1001_0000}, // 30 R4
        {4'd10, 8'b1101_0010}, // 31 R10 new phase during release
        {4'd10, 8'b1101_0010}, // 32
        {4'd10, 8'b1101_0010}, // 33
        {4'd10, 8'b1101_0011}, // 34 R10 charge after gap
        {4'd6,  8'b1101_1011}, // 35 R6 flag ignored while charging
        {4'd7,  8'b1001_1010}, // 36
        {4'd6,  8'b1001_1010}, // 37 R6 flag inside release gap -> idle
        {4'd6,  8'b1001_0010}, // 38 no release after that
        {4'd7,  8'b1110_0010}, // 39 vibration boost
        {4'd7,  8'b1110_0010}, // 40
        {4'd7,  8'b1110_0010}, // 41
        {4'd3,  8'b1110_0011}, // 42 R3
        {4'd7,  8'b1010_0010}, // 43
        {4'd7,  8'b1010_0010}, // 44
        {4'd7,  8'b1010_0010}, // 45
        {4'd4,  8'b1010_0000}, // 46 R4
        {4'd6,  8'b1010_0110}  // 47 R6
    };

    task automatic check(input int req, input logic exp_hs_n, input logic exp_ls);
        checks++;
        if (hs_gate_n !== exp_hs_n || ls_gate !== exp_ls) begin
            fails++;
            $display("FAIL R%0d: hs_gate_n=%b ls_gate=%b expected hs_gate_n=%b ls_gate=%b at %0t",
                     req, hs_gate_n, ls_gate, exp_hs_n, exp_ls, $time);
        end
    endtask

    // Drive after a falling edge, sample 2 ns after the next rising edge.
    task automatic step(input logic [7:0] b, input int req);
        @(negedge clk);
        {enable, phase, src_sel, buck_sel, zc_thermal, zc_vib} = b[7:2];
        @(posedge clk);
        #2;
        check(req, b[1], b[0]);
    endtask

    initial begin
        rst_n = 1'b0;
        {enable, phase, src_sel, buck_sel, zc_thermal, zc_vib} = 6'b110000;
        repeat (3) @(posedge clk);
        #2;
        check(1, 1'b1, 1'b0); // R1 off during reset with phase high
        @(negedge clk);
        phase = 1'b0;
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check(1, 1'b1, 1'b0); // R1 off after reset

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][7:0], int'(VEC[i][11:8]));
        end

        // R8: disable during charge turns the switch off in the same cycle.
        for (int i = 0; i < 3; i++) step(8'b1100_0010, 7);
        step(8'b1100_0011, 3);
        enable = 1'b0;
        #1;
        check(8, 1'b1, 1'b0); // R8 immediate off
        step(8'b0100_0010, 8);
        step(8'b1100_0010, 8); // R8 re-enable starts a full gap
        step(8'b1100_0010, 8);
        step(8'b1100_0010, 8);
        step(8'b1100_0011, 8);

        // R8: disable during release.
        for (int i = 0; i < 3; i++) step(8'b1000_0010, 7);
        step(8'b1000_0000, 4);
        enable = 1'b0;
        #1;
        check(8, 1'b1, 1'b0); // R8 release switch off at once
        step(8'b0000_0010, 8);
        step(8'b1000_0010, 8); // R8 no release resumes after re-enable

        // R7: phase falling during the charge gap leaves both off.
        step(8'b1100_0010, 7);
        step(8'b1000_0010, 7);
        step(8'b1000_0010, 7);
        step(8'b1000_0010, 7);

        // R1: reset in the middle of a charge interval.
        for (int i = 0; i < 3; i++) step(8'b1100_0010, 7);
        step(8'b1100_0011, 3);
        rst_n = 1'b0;
        #1;
        check(1, 1'b1, 1'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule